// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the internals of a byte-wide flash device. It watches write cycles (an address plus an 8-bit command byte) and decides what later read cycles return. A read can return the array contents, the status register or the two identifier bytes. Block erase is a two-write handshake: a setup byte, then a confirm byte. Single writes select a read mode, clear the error flags, or ask a running erase to pause and resume.

The decoder does not time the erase. It sends start, suspend and resume requests to a separate erase sequencer, and it takes back that sequencer's busy, suspended and error indications. It owns the status register, whose error flags stay set until software clears them. The array is modelled as a plain combinational read port, addressed straight from the bus address.

A write is a one-cycle `wr_en` pulse. A read holds `rd_en` high, and `rdata` follows one clock later.

Top module: `fcmd_if`

## Requirements
- R1: After reset the decoder is in array-read mode. `rdata`, `erase_start`, `suspend_req` and `resume_req` are 0, and status bits 5..3 are clear.
- R2: A write of 20h followed by a write of D0h starts an erase when `vpp_high` is 1 and the sequencer is neither busy nor suspended. `erase_start` pulses for one cycle after the confirm write, and `erase_block` carries the top BLK_W bits of the confirm address. Reads then return status.
- R3: If the write after 20h carries any byte other than D0h, no erase starts. Status bit 5 (erase error) is set, and reads return status.
- R4: Writing 90h selects identifier mode. A read at address 0 returns 89h, a read at address 1 returns A2h, and any other address returns 00h.
- R5: Writing 70h selects status mode until another accepted command arrives. The status layout is: bit 7 sequencer ready (not busy), bit 6 suspended, bit 5 erase error, bit 4 byte-write error, bit 3 VPP low, and bits 2..0 read as zero.
- R6: Writing FFh selects array mode, where `rdata` is `arr_data` for the presented address. An unrecognised byte leaves the read mode unchanged.
- R7: Writing 50h clears status bits 5..3, and no other event clears them. A pulse on `seq_err` sets bit 5, and a pulse on `bw_err` sets bit 4.
- R8: An erase confirm written while `vpp_high` is 0 sets status bit 3 and does not start an erase. The 90h, 70h and 50h commands work with `vpp_high` at 0.
- R9: Writing B0h while the sequencer is busy and not suspended pulses `suspend_req` for one cycle and selects status mode. While the sequencer is idle, B0h is ignored.
- R10: While `seq_suspended` is 1, only FFh, 70h and D0h are accepted. D0h pulses `resume_req` and selects status mode, and every other byte (including 90h and 50h) has no effect.
- R11: In status mode the status value is captured on the cycle `rd_en` rises. It is held until `rd_en` drops, and a new read shows any change.
- R12: `rdata` is registered: it shows the selected data one cycle after `rd_en` is sampled high, and it is 00h while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle command write strobe |
| rd_en | input | 1 | Read strobe, held high for the read |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | 8 | Command byte |
| rdata | output | 8 | Registered read data |
| arr_addr | output | ADDR_W | Address to the array read port |
| arr_data | input | 8 | Array read data |
| vpp_high | input | 1 | Programming voltage is valid |
| seq_busy | input | 1 | Erase sequencer is running |
| seq_suspended | input | 1 | Erase sequencer is paused |
| seq_err | input | 1 | Pulse: erase failed |
| bw_err | input | 1 | Pulse: byte write failed |
| erase_start | output | 1 | Pulse: begin erase |
| erase_block | output | BLK_W | Block to erase |
| suspend_req | output | 1 | Pulse: pause erase |
| resume_req | output | 1 | Pulse: continue erase |

## Verification
The bench builds the block with its defaults: a 20-bit address, a 4-bit block field, and identifier bytes 89h and A2h. With these values the block number comes from address bits 19..16, so a confirm address such as 5_1234h proves that the block field is taken from the top of the address. The bench drives the sequencer flags by hand, which reaches the suspended state and its reduced command set without any real erase timing. The two identifier addresses and one out-of-range address sit inside this address width.

// File: rtl/fcmd_pkg.sv
// Package: command codes, read modes and status bit positions shared by
// the decoder, the status register and the read path.
package fcmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2
    } rmode_t;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_IDENT       = 8'h90;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
    localparam logic [7:0] CMD_CLEAR       = 8'h50;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

    // Status bit positions; sticky bits start at SB_STICKY_LSB
    localparam int SB_READY      = 7;
    localparam int SB_SUSP       = 6;
    localparam int SB_STICKY_LSB = 3;
    localparam int N_STICKY      = 3;   // 0: VPP low, 1: byte-write err, 2: erase err

endpackage

// File: rtl/fcmd_decode.sv
// Command decoder: turns write cycles into a read mode, erase-setup
// tracking, sticky-bit set/clear strobes and sequencer requests.
// Assumes wr_en is a single-cycle pulse and that the sequencer
// flags are synchronous to clk.
module fcmd_decode
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              vpp_high,
    input  logic              seq_busy,
    input  logic              seq_suspended,
    output rmode_t            mode,
    output logic              set_vpp,
    output logic              set_abort,
    output logic              clr_sticky,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_block,
    output logic              suspend_req,
    output logic              resume_req
);

    localparam int BLK_LSB = ADDR_W - BLK_W;

    rmode_t mode_q, mode_n;
    logic   setup_q, setup_n;
    logic   start_c, suspend_c, resume_c;

    // Next-state decode of one write cycle
    always_comb begin
        mode_n     = mode_q;
        setup_n    = setup_q;
        start_c    = 1'b0;
        suspend_c  = 1'b0;
        resume_c   = 1'b0;
        set_vpp    = 1'b0;
        set_abort  = 1'b0;
        clr_sticky = 1'b0;
        if (wr_en) begin
            if (setup_q) begin
                setup_n = 1'b0;
                mode_n  = RM_STATUS;
                if (wdata == CMD_CONFIRM) begin
                    if (vpp_high) start_c = 1'b1;
                    else          set_vpp = 1'b1;
                end else begin
                    set_abort = 1'b1;
                end
            end else if (seq_suspended) begin
                case (wdata)
                    CMD_READ_ARRAY: mode_n = RM_ARRAY;
                    CMD_STATUS:     mode_n = RM_STATUS;
                    CMD_CONFIRM: begin
                        resume_c = 1'b1;
                        mode_n   = RM_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                case (wdata)
                    CMD_READ_ARRAY: mode_n = RM_ARRAY;
                    CMD_STATUS:     mode_n = RM_STATUS;
                    CMD_IDENT:      mode_n = RM_IDENT;
                    CMD_CLEAR:      clr_sticky = 1'b1;
                    CMD_ERASE_SETUP: begin
                        if (!seq_busy) setup_n = 1'b1;
                    end
                    CMD_SUSPEND: begin
                        if (seq_busy) begin
                            suspend_c = 1'b1;
                            mode_n    = RM_STATUS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register mode, setup flag and one-cycle sequencer requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= RM_ARRAY;
            setup_q     <= 1'b0;
            erase_start <= 1'b0;
            erase_block <= '0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
        end else begin
            mode_q      <= mode_n;
            setup_q     <= setup_n;
            erase_start <= start_c;
            suspend_req <= suspend_c;
            resume_req  <= resume_c;
            if (start_c) erase_block <= addr[ADDR_W-1:BLK_LSB];
        end
    end

    assign mode = mode_q;

    // R2
    start_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(vpp_high && wr_en && wdata == CMD_CONFIRM));

    // R9
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_start, suspend_req, resume_req}));

    // R10
    resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(seq_suspended && wr_en));

    // R9
    susp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(seq_busy && !seq_suspended));

endmodule

// File: rtl/fcmd_status.sv
// Status register: live sequencer flags and sticky error bits.
// Assumes set strobes are one-cycle. A set wins over a clear in the
// same cycle, so an error is never lost.
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STICKY-1:0] set_vec,
    input  logic                clr,
    input  logic                seq_busy,
    input  logic                seq_suspended,
    output logic [7:0]          status
);

    logic [N_STICKY-1:0] sticky_q;

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        // Hold one error flag until software clears it
        always_ff @(posedge clk) begin
            if (!rst_n)          sticky_q[i] <= 1'b0;
            else if (set_vec[i]) sticky_q[i] <= 1'b1;
            else if (clr)        sticky_q[i] <= 1'b0;
        end

        // R7
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sticky_q[i]) |-> $past(clr));
    end

    // Assemble the status byte from live flags and sticky bits
    always_comb begin
        status = '0;
        status[SB_READY] = ~seq_busy;
        status[SB_SUSP]  = seq_suspended;
        status[SB_STICKY_LSB +: N_STICKY] = sticky_q;
    end

endmodule

// File: rtl/fcmd_read.sv
// Read path: selects array, status or identifier data and registers it.
// The status byte is captured on the rising read strobe and held while
// the strobe stays high.
module fcmd_read
    import fcmd_pkg::*;
#(
    parameter int         ADDR_W = 20,
    parameter logic [7:0] ID_MFR = 8'h89,
    parameter logic [7:0] ID_DEV = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  rmode_t            mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        arr_data,
    input  logic [7:0]        status,
    output logic [7:0]        rdata
);

    logic       rd_q;
    logic [7:0] hold_q;
    logic [7:0] id_byte;

    // Identifier lookup by address
    always_comb begin
        if (addr == ADDR_W'(0))      id_byte = ID_MFR;
        else if (addr == ADDR_W'(1)) id_byte = ID_DEV;
        else                         id_byte = 8'h00;
    end

    // Track the strobe and latch status on its rising cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            hold_q <= 8'h00;
        end else begin
            rd_q <= rd_en;
            if (rd_en && !rd_q) hold_q <= status;
        end
    end

    // Register the selected read data
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en) begin
            rdata <= 8'h00;
        end else begin
            case (mode)
                RM_STATUS: rdata <= rd_q ? hold_q : status;
                RM_IDENT:  rdata <= id_byte;
                default:   rdata <= arr_data;
            endcase
        end
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_q) |=> $stable(hold_q));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 8'h00));

endmodule

// File: rtl/fcmd_if.sv
// Top level of the flash command interface: wires the decoder, the
// status register and the read path together. The array read port is
// addressed straight from the bus address.
module fcmd_if
    import fcmd_pkg::*;
#(
    parameter int         ADDR_W = 20,
    parameter int         BLK_W  = 4,
    parameter logic [7:0] ID_MFR = 8'h89,
    parameter logic [7:0] ID_DEV = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_data,
    input  logic              vpp_high,
    input  logic              seq_busy,
    input  logic              seq_suspended,
    input  logic              seq_err,
    input  logic              bw_err,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_block,
    output logic              suspend_req,
    output logic              resume_req
);

    rmode_t              mode;
    logic                set_vpp, set_abort, clr_sticky;
    logic [N_STICKY-1:0] set_vec;
    logic [7:0]          status;

    fcmd_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .clk, .rst_n, .wr_en, .addr, .wdata, .vpp_high,
        .seq_busy, .seq_suspended,
        .mode, .set_vpp, .set_abort, .clr_sticky,
        .erase_start, .erase_block, .suspend_req, .resume_req
    );

    // Map error sources onto the sticky bits: 0 VPP, 1 byte write, 2 erase
    assign set_vec = {set_abort | seq_err, bw_err, set_vpp};

    fcmd_status u_stat (
        .clk, .rst_n, .set_vec, .clr(clr_sticky),
        .seq_busy, .seq_suspended, .status
    );

    fcmd_read #(.ADDR_W(ADDR_W), .ID_MFR(ID_MFR), .ID_DEV(ID_DEV)) u_rd (
        .clk, .rst_n, .rd_en, .mode, .addr, .arr_data, .status, .rdata
    );

    assign arr_addr = addr;

endmodule

// File: tb/tb_fcmd_if.sv
module tb_fcmd_if;

    localparam int ADDR_W = 20;
    localparam int BLK_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data;
    logic              vpp_high = 1'b1, seq_busy = 1'b0, seq_suspended = 1'b0;
    logic              seq_err = 1'b0, bw_err = 1'b0;
    logic              erase_start, suspend_req, resume_req;
    logic [BLK_W-1:0]  erase_block;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Array model: data is a fixed function of the address
    assign arr_data = arr_addr[7:0] ^ 8'h5A;

    fcmd_if dut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
        .arr_addr, .arr_data, .vpp_high, .seq_busy, .seq_suspended,
        .seq_err, .bw_err, .erase_start, .erase_block,
        .suspend_req, .resume_req
    );

    // Vector: {is_write, addr[19:0], data or expected read byte}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 20'h00010, 8'h4A},   // R6 array at reset
        {1'b1, 20'h00000, 8'h90},
        {1'b0, 20'h00000, 8'h89},   // R4
        {1'b0, 20'h00001, 8'hA2},   // R4
        {1'b1, 20'h00000, 8'h70},
        {1'b0, 20'h00005, 8'h80},   // R5
        {1'b1, 20'h00000, 8'hFF},
        {1'b0, 20'h00033, 8'h69},   // R6
        {1'b1, 20'h00000, 8'h42},
        {1'b0, 20'h00033, 8'h69},   // R6 unknown ignored
        {1'b1, 20'h00000, 8'h90},
        {1'b1, 20'h00000, 8'h42},
        {1'b0, 20'h00001, 8'hA2}    // R6 ident retained
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] got);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        got = rdata;
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 requests", {erase_start, suspend_req, resume_req}, 3'b000);
        chk("R12 idle rdata", rdata, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) wr(VEC[i][27:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][27:8], r);
                chk($sformatf("R4/R5/R6 vec%0d", i), r, VEC[i][7:0]);
            end
        end

        // R1 sticky clear after reset: status 80h
        wr(0, 8'h70); rd(0, r); chk("R1 status", r, 8'h80);

        // R2 erase start
        wr(20'h51234, 8'h20);
        wr(20'h51234, 8'hD0);
        chk("R2 start", erase_start, 1'b1);
        chk("R2 block", erase_block, 4'h5);
        @(negedge clk);
        chk("R2 pulse width", erase_start, 1'b0);
        wr(0, 8'hFF); wr(0, 8'h20); wr(20'h51234, 8'hD0);
        rd(20'h00010, r); chk("R2 status after confirm", r, 8'h80);

        // R3 bad second byte
        wr(0, 8'h20);
        wr(0, 8'h40);
        chk("R3 no start", erase_start, 1'b0);
        rd(0, r); chk("R3 erase err", r, 8'hA0);
        wr(0, 8'h50); rd(0, r); chk("R7 clear", r, 8'h80);

        // R8 VPP low
        vpp_high = 1'b0;
        wr(0, 8'h20); wr(20'h31000, 8'hD0);
        chk("R8 no start", erase_start, 1'b0);
        rd(0, r); chk("R8 vpp bit", r, 8'h88);
        wr(0, 8'h90); rd(1, r); chk("R8 ident at low vpp", r, 8'hA2);
        wr(0, 8'h50); wr(0, 8'h70); rd(0, r); chk("R8 clear at low vpp", r, 8'h80);
        vpp_high = 1'b1;

        // R7 sequencer and byte-write errors
        @(negedge clk); seq_err = 1'b1; bw_err = 1'b1;
        @(negedge clk); seq_err = 1'b0; bw_err = 1'b0;
        rd(0, r); chk("R7 sticky set", r, 8'hB0);
        wr(0, 8'hFF); wr(0, 8'h70); rd(0, r); chk("R7 no clear by others", r, 8'hB0);
        wr(0, 8'h50); rd(0, r); chk("R7 cleared", r, 8'h80);

        // R9 suspend ignored when idle
        wr(0, 8'hFF); wr(0, 8'hB0);
        chk("R9 idle no req", suspend_req, 1'b0);
        rd(20'h00010, r); chk("R9 idle mode kept", r, 8'h4A);

        // R9 suspend while busy
        seq_busy = 1'b1;
        wr(0, 8'hB0);
        chk("R9 suspend req", suspend_req, 1'b1);
        rd(0, r); chk("R9 status busy", r, 8'h00);

        // R10 suspended state
        seq_busy = 1'b0; seq_suspended = 1'b1;
        vpp_high = 1'b0;
        wr(0, 8'h20); wr(0, 8'hD0);  // 20 ignored, D0 resumes
        chk("R10 resume", resume_req, 1'b1);
        vpp_high = 1'b1;
        @(negedge clk); seq_err = 1'b1; @(negedge clk); seq_err = 1'b0;
        wr(0, 8'h50);
        wr(0, 8'h90);
        rd(0, r); chk("R10 clear/ident ignored", r, 8'hE0);
        wr(0, 8'hFF); rd(20'h00033, r); chk("R10 array allowed", r, 8'h69);
        wr(0, 8'h70); rd(0, r); chk("R10 status allowed", r, 8'hE0);
        wr(0, 8'hFF); wr(0, 8'hD0);
        chk("R10 resume req", resume_req, 1'b1);
        rd(0, r); chk("R10 status after resume", r, 8'hE0);
        seq_suspended = 1'b0;
        wr(0, 8'h50); rd(0, r); chk("R7 clear after resume", r, 8'h80);

        // R11 capture and hold
        @(negedge clk); rd_en = 1'b1; addr = '0;
        @(negedge clk); chk("R11 first", rdata, 8'h80);
        seq_busy = 1'b1;
        @(negedge clk); chk("R11 held", rdata, 8'h80);
        @(negedge clk); chk("R11 still held", rdata, 8'h80);
        rd_en = 1'b0;
        @(negedge clk); chk("R12 zero after read", rdata, 8'h00);
        rd(0, r); chk("R11 new read", r, 8'h00);
        seq_busy = 1'b0;

        // R1 reset returns to array mode
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd(20'h00010, r); chk("R1 array after reset", r, 8'h4A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule